// File: doc/BRIEF.md
# Quad Addressed DAC Code Latch

This block models the digital input side of a four-channel, 8-bit voltage-output converter. A host drives one shared data bus, a two-bit channel address and an active-low write strobe. Each channel keeps its own code register, and that code sets the channel's output. While the strobe is low, the addressed channel is open and follows the bus. When the strobe rises, the channel keeps the last value it took. While the strobe is high, every input is ignored.

The block runs on a fast sampling clock, and all inputs are sampled on its rising edge. It also gives each channel's ideal output level in millivolts. This level equals the code times the reference, divided by 256.

A timing checker watches every write in clock cycles. It raises a sticky flag if the data was not stable long enough before the strobe rose, and another if the strobe was not low long enough. Address setup, address hold and data hold have zero minimums, so nothing checks them.

Top module: `quad_dac_latch`

## Requirements
- R1: The address selects the channel: 0 selects channel index 0 (bits 7:0 of `code_o`), 1 selects index 1 (bits 15:8), 2 selects index 2 (bits 23:16) and 3 selects index 3 (bits 31:24). A write changes only the selected channel.
- R2: While `wr_ni` is sampled high, no channel code changes, whatever the address and data inputs do.
- R3: For every clock edge at which `wr_ni` is sampled low, the addressed channel's code equals the sampled data from the next cycle onward. The output therefore follows the bus with one cycle of latency.
- R4: After the strobe rises, the channel keeps the data sampled in the last low cycle. It holds that value while the strobe stays high.
- R5: If the address changes while the strobe is low, the channel addressed before the change keeps the value it held at the change. The newly addressed channel starts to follow the bus.
- R6: Asynchronous reset (`rst_ni` low) clears all four codes, all levels and both violation flags to 0.
- R7: Each channel's `level_o` field equals floor(code × REF_MV / 256), with straight binary coding. With REF_MV = 10000, code 255 gives 9960, code 128 gives 5000 and code 1 gives 39.
- R8: A rising strobe sets `setup_viol_o` from the next cycle onward if the data sampled in the last low cycle was stable for fewer than SETUP_CYC consecutive samples. The flag stays set until reset.
- R9: A rising strobe sets `width_viol_o` from the next cycle onward if the strobe was sampled low for fewer than PW_CYC consecutive cycles. The flag stays set until reset.
- R10: Writes that meet both minimums leave both flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Channel address |
| data_i | input | 8 | Shared code bus |
| code_o | output | 32 | Four 8-bit channel codes, channel 0 in the low byte |
| level_o | output | 64 | Four 16-bit ideal output levels in mV, channel 0 in the low field |
| setup_viol_o | output | 1 | Sticky data-setup violation |
| width_viol_o | output | 1 | Sticky strobe-width violation |

## Verification
A fault in the channel-select decode or a latch enable shows up as a wrong byte of `code_o` one cycle after the offending sample. Such a fault also corrupts a neighbour's stored code, and that error persists at the ports until the neighbour is rewritten.

A stability or width counter that is off by one changes the violation flags only in the cycle after a rising strobe whose count sits exactly at the minimum. For that reason the bench runs pulses on both sides of each limit. The level fields are pure logic on the codes, so a scaling fault appears in the same cycle as the code it belongs to.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int unsigned N_CH_DEF   = 4;
  localparam int unsigned CODE_W_DEF = 8;
  localparam int unsigned LVL_W_DEF  = 16;
endpackage

// File: rtl/qdl_sel_decode.sv
module qdl_sel_decode #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_CH-1:0]   sel_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_sel
    assign sel_o[g] = !wr_ni && (addr_i == ADDR_W'(g));
  end

  // R1: at most one latch open at any time
  always_comb p_sel_onehot_r1: assert ($onehot0(sel_o));
endmodule

// File: rtl/qdl_channel.sv
module qdl_channel #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned LVL_W  = 16,
  parameter int unsigned REF_MV = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic [LVL_W-1:0]  level_o
);
  localparam int unsigned PROD_W = CODE_W + LVL_W;

  logic [PROD_W-1:0] prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_o <= '0;
    else if (we_i) code_o <= data_i;
  end

  assign prod    = PROD_W'(code_o) * PROD_W'(REF_MV);
  assign level_o = prod[CODE_W +: LVL_W];

  // R7: full scale stays one step below the reference
  always_comb if (rst_ni) p_level_below_ref_r7: assert (32'(level_o) < REF_MV);
endmodule

// File: rtl/qdl_timing_chk.sv
module qdl_timing_chk #(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned SETUP_CYC = 5,
  parameter int unsigned PW_CYC    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic [CODE_W-1:0] data_i,
  output logic              setup_viol_o,
  output logic              width_viol_o
);
  localparam int unsigned LIM   = (SETUP_CYC > PW_CYC) ? SETUP_CYC : PW_CYC;
  localparam int unsigned CNT_W = $clog2(LIM + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              wr_q;
  logic [CODE_W-1:0] data_q;
  logic [CNT_W-1:0]  low_cnt, stab_cnt;
  logic              rise;

  assign rise = wr_ni && !wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q         <= 1'b1;
      data_q       <= '0;
      low_cnt      <= '0;
      stab_cnt     <= '0;
      setup_viol_o <= 1'b0;
      width_viol_o <= 1'b0;
    end else begin
      wr_q   <= wr_ni;
      data_q <= data_i;
      if (wr_ni)                  low_cnt <= '0;
      else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
      if (data_i != data_q)        stab_cnt <= CNT_W'(1);
      else if (stab_cnt != CNT_MAX) stab_cnt <= stab_cnt + 1'b1;
      if (rise && (32'(stab_cnt) < SETUP_CYC)) setup_viol_o <= 1'b1;
      if (rise && (32'(low_cnt) < PW_CYC))     width_viol_o <= 1'b1;
    end
  end

  p_setup_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_viol_o |=> setup_viol_o);
  p_width_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_viol_o |=> width_viol_o);
endmodule

// File: rtl/quad_dac_latch.sv
module quad_dac_latch #(
  parameter int unsigned N_CH      = quad_dac_pkg::N_CH_DEF,
  parameter int unsigned CODE_W    = quad_dac_pkg::CODE_W_DEF,
  parameter int unsigned LVL_W     = quad_dac_pkg::LVL_W_DEF,
  parameter int unsigned REF_MV    = 10000,
  parameter int unsigned SETUP_CYC = 5,
  parameter int unsigned PW_CYC    = 5,
  localparam int unsigned ADDR_W   = $clog2(N_CH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_ni,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [CODE_W-1:0]            data_i,
  output logic [N_CH-1:0][CODE_W-1:0]  code_o,
  output logic [N_CH-1:0][LVL_W-1:0]   level_o,
  output logic                         setup_viol_o,
  output logic                         width_viol_o
);
  logic [N_CH-1:0] sel;

  qdl_sel_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr_ni (wr_ni),
    .addr_i(addr_i),
    .sel_o (sel)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    qdl_channel #(.CODE_W(CODE_W), .LVL_W(LVL_W), .REF_MV(REF_MV)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (sel[g]),
      .data_i (data_i),
      .code_o (code_o[g]),
      .level_o(level_o[g])
    );
  end

  qdl_timing_chk #(.CODE_W(CODE_W), .SETUP_CYC(SETUP_CYC), .PW_CYC(PW_CYC)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_ni       (wr_ni),
    .data_i      (data_i),
    .setup_viol_o(setup_viol_o),
    .width_viol_o(width_viol_o)
  );

  p_hold_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ni |=> $stable(code_o));
  p_follow_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ni |=> code_o[$past(addr_i)] == $past(data_i));
endmodule

// File: tb/quad_dac_latch_bench.sv
module quad_dac_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REF_MV = 10000;
  localparam int SETUP_CYC = 5;
  localparam int PW_CYC = 5;

  typedef struct {
    int          due;
    logic [31:0] code;
    logic        sv;
    logic        wv;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  data = '0;
  logic [3:0][7:0]  code;
  logic [3:0][15:0] level;
  logic        sv, wv;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  item_t q[$];

  logic [7:0] m_code [4];
  logic       m_sv, m_wv, m_pwr;
  logic [7:0] m_pdata;
  int         m_low, m_stab;

  quad_dac_latch #(.REF_MV(REF_MV), .SETUP_CYC(SETUP_CYC), .PW_CYC(PW_CYC)) u_quad_dac_latch (
    .clk_i(clk), .rst_ni(rst_n), .wr_ni(wr_n), .addr_i(addr), .data_i(data),
    .code_o(code), .level_o(level), .setup_viol_o(sv), .width_viol_o(wv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] pack_model();
    return {m_code[3], m_code[2], m_code[1], m_code[0]};
  endfunction

  function automatic logic [63:0] levels_of(input logic [31:0] c);
    logic [63:0] r;
    for (int i = 0; i < 4; i++) r[i*16 +: 16] = 16'((int'(c[i*8 +: 8]) * REF_MV) / 256);
    return r;
  endfunction

  task automatic compare(input logic [31:0] ec, input logic esv, input logic ewv, input string tag);
    logic [63:0] el;
    el = levels_of(ec);
    n_chk++;
    if (code !== ec || level !== el || sv !== esv || wv !== ewv) begin
      n_bad++;
      $display("FAIL %s: code=%h level=%h sv=%b wv=%b expected code=%h level=%h sv=%b wv=%b",
               tag, code, level, sv, wv, ec, el, esv, ewv);
    end
  endtask

  // monitor: pops expected items once their cycle has arrived
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      compare(it.code, it.sv, it.wv, it.tag);
    end
  end

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_code[i] = '0;
    m_sv = 0; m_wv = 0; m_pwr = 1; m_pdata = '0; m_low = 0; m_stab = 0;
  endtask

  // driver: one sampled cycle of stimulus plus its expected result
  task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d, input string tag);
    item_t it;
    @(negedge clk);
    wr_n = w; addr = a; data = d;
    if (w && !m_pwr) begin
      if (m_low < PW_CYC) m_wv = 1;
      if (m_stab < SETUP_CYC) m_sv = 1;
    end
    m_low  = w ? 0 : m_low + 1;
    m_stab = (d == m_pdata) ? m_stab + 1 : 1;
    m_pdata = d;
    m_pwr = w;
    if (!w) m_code[a] = d;
    it.due = cyc + 1; it.code = pack_model(); it.sv = m_sv; it.wv = m_wv; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic clean_write(input logic [1:0] a, input logic [7:0] d, input string tag);
    repeat (SETUP_CYC) step(1'b1, a, d, tag);
    repeat (PW_CYC) step(1'b0, a, d, tag);
    repeat (2) step(1'b1, a, d, tag);
  endtask

  task automatic do_reset(input string tag);
    wait (q.size() == 0);
    @(negedge clk);
    rst_n = 0; wr_n = 1; addr = '0; data = '0;
    model_reset();
    repeat (2) @(negedge clk);
    compare(32'h0, 1'b0, 1'b0, tag);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset("R6 reset state");
    // R2: bus and address toggle with strobe high
    for (int i = 0; i < 8; i++) step(1'b1, 2'(i), 8'(8'h5A ^ i*37), "R2 idle ignored");
    // R1/R4/R10: clean writes to every channel
    clean_write(2'd0, 8'h11, "R1 R4 ch0");
    clean_write(2'd1, 8'h22, "R1 R4 ch1");
    clean_write(2'd2, 8'h33, "R1 R4 ch2");
    clean_write(2'd3, 8'h44, "R1 R4 R10 ch3");
    // R7: scaling points
    clean_write(2'd0, 8'hFF, "R7 full scale");
    clean_write(2'd1, 8'h80, "R7 half scale");
    clean_write(2'd2, 8'h01, "R7 one lsb");
    clean_write(2'd3, 8'h00, "R7 zero");
    // R5: address moves while strobe is low
    repeat (SETUP_CYC) step(1'b1, 2'd1, 8'h3C, "R5 setup");
    repeat (3) step(1'b0, 2'd1, 8'h3C, "R5 first addr");
    repeat (6) step(1'b0, 2'd2, 8'hA5, "R5 second addr");
    repeat (3) step(1'b1, 2'd0, 8'h77, "R5 R10 hold");
    // R3/R8: bus moves while strobe is low, then rises too soon after last change
    for (int i = 0; i < 6; i++) step(1'b0, 2'd3, 8'(8'h10 + i*19), "R3 follow");
    repeat (3) step(1'b1, 2'd3, 8'hEE, "R8 setup flag");
    repeat (4) step(1'b1, 2'd0, 8'h00, "R8 sticky");
    do_reset("R6 reset clears flags");
    // R9: short strobe with stable data; exact limit pulse first stays clean
    clean_write(2'd1, 8'h66, "R10 at limit");
    repeat (SETUP_CYC + 1) step(1'b1, 2'd2, 8'h99, "R9 setup");
    repeat (PW_CYC - 1) step(1'b0, 2'd2, 8'h99, "R9 short low");
    repeat (3) step(1'b1, 2'd2, 8'h99, "R9 width flag");
    wait (q.size() == 0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule